// File: doc/BRIEF.md
# Multi-Stage Trigger Sequencer

The block watches a 16-channel sample bus and walks through a programmable chain of trigger stages. Each stage holds two comparators, A and B. Every channel of a comparator can be ignored, tested for a level, or tested for an edge against the previous valid sample. Each stage picks how A and B combine and sets how many qualifying samples it needs before the sequencer moves to the next stage. Satisfying the final stage produces a one-cycle trigger strobe and a trigger-out pulse whose width is programmable. The sequencer then holds in a triggered state until it is armed again.

Samples arrive as a valid-qualified stream with no ready signal. The block accepts a sample on every cycle, so it never applies back-pressure. Cycles with `smp_valid` low are not evaluated at all. Configuration is written through a plain address/data/write-enable port. Arm and stop are plain control inputs. Every output changes on a clock edge: a qualifying sample shows its effect on the outputs in the cycle after it is presented.

Register map (address `{global, stage[3:0], reg[2:0]}`):
- Stage registers (global = 0):
  - reg 0: A select `{edge[15:0], care[15:0]}`
  - reg 1: A value `{any[15:0], value[15:0]}`
  - reg 2: B select
  - reg 3: B value
  - reg 4: control `{combine[17:16], count[15:0]}`
- Global registers (global = 1):
  - reg 0: last stage index `[3:0]`
  - reg 1: pulse width `[15:0]`

All registers reset to zero.

Top module: `trig_seq`

## Requirements
- R1: After reset the sequencer is idle: `running`, `triggered`, `trig_strobe` and `trig_out` are 0 and `cur_stage` is 0.
- R2: A channel with care=0 is ignored. A channel with care=1 and edge=0 matches when the sample bit equals the value bit.
- R3: A channel with care=1 and edge=1 is an edge test against the previous valid sample. With any=1 either transition matches. With any=0, value=1 means rising and value=0 means falling. Several edge channels in one comparator must all match on the same sample. Samples with `smp_valid` low neither match nor replace the previous sample.
- R4: The stage condition follows combine: 0 = A only, 1 = A AND B, 2 = A OR B. Code 3 behaves as 0.
- R5: A stage advances after its condition has held on `count` valid samples, counted cumulatively (not necessarily consecutive). A count of 0 acts as 1. The stage moves by at most one step per sample.
- R6: The chain runs from stage 0 to the programmed last index. `cur_stage` shows the active stage and never exceeds the last index while running.
- R7: Completing the last stage raises `trig_strobe` for exactly one cycle and sets `triggered`. Further samples give no strobe until the sequencer is re-armed.
- R8: `trig_out` goes high in the same cycle as the strobe and stays high for max(width,1) clock cycles.
- R9: Configuration writes issued while `running` is 1 are ignored.
- R10: `arm` (which has priority over `stop`) enters the running state at stage 0 with all occurrence counts cleared, from any state.
- R11: `stop` returns the sequencer to idle at stage 0; no trigger can occur while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample on `smp_data` is valid this cycle |
| smp_data | input | 16 | Sampled channels |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| arm | input | 1 | Start or restart the sequence |
| stop | input | 1 | Return to idle |
| trig_strobe | output | 1 | One-cycle trigger event |
| trig_out | output | 1 | Stretched trigger pulse |
| cur_stage | output | 4 | Active stage index |
| running | output | 1 | Sequencer is armed and evaluating |
| triggered | output | 1 | Final stage completed, waiting for re-arm |

## Verification
The assertions take for granted that these inputs are always known values once reset is released: `smp_valid`, `arm`, `stop` and `cfg_we`. They also assume the last-stage index is only changed while the sequencer is not running; this is what makes the stage bound meaningful. The stimulus drives every input one time unit after a rising edge and holds it for a full cycle. It writes configuration only while idle or triggered, except in the one test that checks writes are ignored. It always issues a stop before reprogramming, so no run ever sees a last index below its current stage.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int CH_W  = 16;
  localparam int CNT_W = 16;

  localparam logic [1:0] COMB_A   = 2'd0;
  localparam logic [1:0] COMB_AND = 2'd1;
  localparam logic [1:0] COMB_OR  = 2'd2;

  typedef struct packed {
    logic [CH_W-1:0] any;
    logic [CH_W-1:0] val;
    logic [CH_W-1:0] edg;
    logic [CH_W-1:0] care;
  } cmp_cfg_t;

  typedef struct packed {
    cmp_cfg_t         a;
    cmp_cfg_t         b;
    logic [1:0]       comb;
    logic [CNT_W-1:0] need;
  } stage_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/trig_seq_cmp.sv
module trig_seq_cmp
  import trig_seq_pkg::*;
(
  input  cmp_cfg_t        cfg,
  input  logic [CH_W-1:0] cur,
  input  logic [CH_W-1:0] prev,
  output logic            hit
);
  logic [CH_W-1:0] rise, fall, lvl_ok, edge_ok, bit_ok;

  always_comb begin
    rise    = cur & ~prev;
    fall    = ~cur & prev;
    lvl_ok  = ~(cur ^ cfg.val);
    edge_ok = (cfg.any & (rise | fall)) |
              (~cfg.any & ((cfg.val & rise) | (~cfg.val & fall)));
    bit_ok  = ~cfg.care | (cfg.edg & edge_ok) | (~cfg.edg & lvl_ok);
    hit     = &bit_ok;
  end
endmodule

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
  import trig_seq_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int SIDX_W = 4,
  parameter int ADDR_W = SIDX_W + 4,
  parameter int PW_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              lock,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [SIDX_W-1:0] rd_stage,
  output stage_cfg_t        rd_cfg,
  output logic [SIDX_W-1:0] last_idx,
  output logic [PW_W-1:0]   stretch
);
  localparam int CTL_HI = CNT_W + 1;

  logic              wr_ok, glob;
  logic [2:0]        rsel;
  logic [SIDX_W-1:0] ssel;
  stage_cfg_t        bank [STAGES];
  logic              unused_bits;

  assign wr_ok = we && !lock;
  assign glob  = addr[ADDR_W-1];
  assign rsel  = addr[2:0];
  assign ssel  = addr[ADDR_W-2:3];
  assign unused_bits = ^{wdata[31:CTL_HI+1]};

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    stage_cfg_t r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (wr_ok && !glob && ssel == SIDX_W'(gi)) begin
        case (rsel)
          3'd0: begin r_q.a.edg <= wdata[2*CH_W-1:CH_W]; r_q.a.care <= wdata[CH_W-1:0]; end
          3'd1: begin r_q.a.any <= wdata[2*CH_W-1:CH_W]; r_q.a.val  <= wdata[CH_W-1:0]; end
          3'd2: begin r_q.b.edg <= wdata[2*CH_W-1:CH_W]; r_q.b.care <= wdata[CH_W-1:0]; end
          3'd3: begin r_q.b.any <= wdata[2*CH_W-1:CH_W]; r_q.b.val  <= wdata[CH_W-1:0]; end
          3'd4: begin r_q.comb  <= wdata[CTL_HI:CNT_W];  r_q.need   <= wdata[CNT_W-1:0]; end
          default: ;
        endcase
      end
    end
    assign bank[gi] = r_q;
  end

  assign rd_cfg = bank[rd_stage];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx <= '0;
      stretch  <= '0;
    end else if (wr_ok && glob) begin
      if (rsel == 3'd0) last_idx <= wdata[SIDX_W-1:0];
      if (rsel == 3'd1) stretch  <= wdata[PW_W-1:0];
    end
  end

  // R9: a locked write leaves the global settings untouched
  assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> ($stable(last_idx) && $stable(stretch)));
endmodule

// File: rtl/trig_seq_pulse.sv
module trig_seq_pulse #(
  parameter int PW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [PW_W-1:0] width,
  output logic            pulse
);
  logic [PW_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (fire)           cnt_q <= (width == '0) ? PW_W'(1) : width;
    else if (cnt_q != '0)    cnt_q <= cnt_q - PW_W'(1);
  end

  assign pulse = (cnt_q != '0);

  // R8: the pulse is high on the cycle after a fire request
  assert_pulse_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse);
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int  STAGES = 16,
  parameter int  PW_W   = 16,
  localparam int SIDX_W = $clog2(STAGES),
  localparam int ADDR_W = SIDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              arm,
  input  logic              stop,
  output logic              trig_strobe,
  output logic              trig_out,
  output logic [SIDX_W-1:0] cur_stage,
  output logic              running,
  output logic              triggered
);
  seq_state_t        st_q;
  logic [SIDX_W-1:0] stg_q;
  logic [CNT_W-1:0]  occ_q;
  logic [CH_W-1:0]   prev_q;
  logic              strobe_q;

  stage_cfg_t        scfg;
  logic [SIDX_W-1:0] last_idx;
  logic [PW_W-1:0]   stretch;
  logic [1:0]        hit;
  logic              cond, step, reach, fire_c;
  logic [CNT_W:0]    need_eff, occ_nxt;

  trig_seq_cfg #(
    .STAGES(STAGES), .SIDX_W(SIDX_W), .ADDR_W(ADDR_W), .PW_W(PW_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .lock(st_q == ST_RUN),
    .addr(cfg_addr), .wdata(cfg_wdata), .rd_stage(stg_q),
    .rd_cfg(scfg), .last_idx(last_idx), .stretch(stretch)
  );

  for (genvar gc = 0; gc < 2; gc++) begin : g_cmp
    cmp_cfg_t sel;
    assign sel = (gc == 0) ? scfg.a : scfg.b;
    trig_seq_cmp u_cmp (.cfg(sel), .cur(smp_data), .prev(prev_q), .hit(hit[gc]));
  end

  always_comb begin
    case (scfg.comb)
      COMB_AND: cond = hit[0] & hit[1];
      COMB_OR:  cond = hit[0] | hit[1];
      default:  cond = hit[0];
    endcase
    need_eff = (scfg.need == '0) ? (CNT_W+1)'(1) : {1'b0, scfg.need};
    occ_nxt  = {1'b0, occ_q} + (CNT_W+1)'(1);
    reach    = (occ_nxt >= need_eff);
    step     = (st_q == ST_RUN) && smp_valid && cond && !arm && !stop;
    fire_c   = step && reach && (stg_q == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      stg_q    <= '0;
      occ_q    <= '0;
      prev_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= fire_c;
      if (smp_valid) prev_q <= smp_data;
      if (arm) begin
        st_q  <= ST_RUN;
        stg_q <= '0;
        occ_q <= '0;
      end else if (stop) begin
        st_q  <= ST_IDLE;
        stg_q <= '0;
        occ_q <= '0;
      end else if (step) begin
        if (reach) begin
          occ_q <= '0;
          if (stg_q == last_idx) st_q  <= ST_DONE;
          else                   stg_q <= stg_q + SIDX_W'(1);
        end else begin
          occ_q <= occ_nxt[CNT_W-1:0];
        end
      end
    end
  end

  trig_seq_pulse #(.PW_W(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire_c), .width(stretch), .pulse(trig_out)
  );

  assign trig_strobe = strobe_q;
  assign cur_stage   = stg_q;
  assign running     = (st_q == ST_RUN);
  assign triggered   = (st_q == ST_DONE);

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_strobe |=> !trig_strobe);
  assert_strobe_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_strobe |-> (triggered && trig_out));
  assert_stage_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cur_stage <= last_idx));
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !arm && !stop) |=>
      (!running || cur_stage == $past(cur_stage) || cur_stage == $past(cur_stage) + SIDX_W'(1)));
  assert_arm_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (running && cur_stage == '0));
endmodule

// File: tb/trig_seq_tb.sv
module trig_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        arm = 1'b0;
  logic        stop = 1'b0;
  logic        trig_strobe, trig_out, running, triggered;
  logic [3:0]  cur_stage;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_seq u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .arm(arm), .stop(stop), .trig_strobe(trig_strobe), .trig_out(trig_out),
    .cur_stage(cur_stage), .running(running), .triggered(triggered)
  );

  // {care, edge, any, value, prev, cur, expect}
  localparam int NV = 13;
  localparam logic [96:0] VEC [NV] = '{
    {16'h00FF, 16'h0000, 16'h0000, 16'h00A5, 16'h0000, 16'h12A5, 1'b1}, // R2 masked level
    {16'h00FF, 16'h0000, 16'h0000, 16'h00A5, 16'h0000, 16'h00A4, 1'b0}, // R2 mismatch
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h3C3C, 1'b1}, // R2 all ignored
    {16'h0001, 16'h0001, 16'h0000, 16'h0001, 16'h0000, 16'h0001, 1'b1}, // R3 rising
    {16'h0001, 16'h0001, 16'h0000, 16'h0001, 16'h0001, 16'h0001, 1'b0}, // R3 no rise
    {16'h0008, 16'h0008, 16'h0000, 16'h0000, 16'h0008, 16'h0000, 1'b1}, // R3 falling
    {16'h0008, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h0008, 1'b0}, // R3 wrong dir
    {16'h8000, 16'h8000, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 1'b1}, // R3 either, fall
    {16'h8000, 16'h8000, 16'h8000, 16'h0000, 16'h0000, 16'h8000, 1'b1}, // R3 either, rise
    {16'h0003, 16'h0003, 16'h0000, 16'h0001, 16'h0002, 16'h0001, 1'b1}, // R3 two edges
    {16'h0003, 16'h0003, 16'h0000, 16'h0001, 16'h0000, 16'h0001, 1'b0}, // R3 one edge missing
    {16'h0101, 16'h0001, 16'h0000, 16'h0101, 16'h0100, 16'h0101, 1'b1}, // R3 edge+level
    {16'h0101, 16'h0001, 16'h0000, 16'h0101, 16'h0000, 16'h0001, 1'b0}  // R3 level fails
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] sa(input int s, input int r);
    return {1'b0, 4'(s), 3'(r)};
  endfunction

  task automatic do_arm();
    arm = 1'b1; tick(); arm = 1'b0;
  endtask

  task automatic do_stop();
    stop = 1'b1; tick(); stop = 1'b0;
  endtask

  task automatic smp(input logic [15:0] d);
    smp_valid = 1'b1; smp_data = d; tick(); smp_valid = 1'b0;
  endtask

  // level compare on one bit for comparator A (sel reg) and B
  task automatic stage_lvl(input int s, input logic [15:0] abit, input logic [15:0] bbit,
                           input logic [1:0] comb, input logic [15:0] need);
    wr(sa(s, 0), {16'h0, abit});
    wr(sa(s, 1), {16'h0, abit});
    wr(sa(s, 2), {16'h0, bbit});
    wr(sa(s, 3), {16'h0, bbit});
    wr(sa(s, 4), {14'h0, comb, need});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    check("R1 running", running, 0);
    check("R1 triggered", triggered, 0);
    check("R1 strobe", trig_strobe, 0);
    check("R1 trig_out", trig_out, 0);
    check("R1 cur_stage", cur_stage, 0);
    rst_n = 1'b1;
    tick();

    // table walk: single stage, comparator A only, width 0 -> 1-cycle pulse
    wr(8'h80, 32'h0);
    wr(8'h81, 32'h0);
    for (int i = 0; i < NV; i++) begin
      logic [96:0] v;
      v = VEC[i];
      do_stop();
      wr(sa(0, 0), {v[80:65], v[96:81]});
      wr(sa(0, 1), {v[64:49], v[48:33]});
      wr(sa(0, 4), {14'h0, 2'd0, 16'd1});
      smp(v[32:17]);
      do_arm();
      smp(v[16:1]);
      check($sformatf("R2/R3 vec%0d strobe", i), trig_strobe, v[0]);
      if (v[0]) begin
        check($sformatf("R8 vec%0d pulse", i), trig_out, 1);
        tick();
        check($sformatf("R8 vec%0d pulse end", i), trig_out, 0);
      end
    end

    // R3 invalid samples are skipped for edges
    do_stop();
    wr(sa(0, 0), {16'h0001, 16'h0001});
    wr(sa(0, 1), {16'h0000, 16'h0001});
    smp(16'h0000);
    do_arm();
    smp_valid = 1'b0; smp_data = 16'h0001; tick();
    check("R3 invalid ignored", trig_strobe, 0);
    smp(16'h0001);
    check("R3 edge vs last valid", trig_strobe, 1);

    // R4 combine modes: A = bit0 high, B = bit1 high
    do_stop();
    stage_lvl(0, 16'h0001, 16'h0002, 2'd1, 16'd1);
    do_arm(); smp(16'h0001);
    check("R4 AND partial", trig_strobe, 0);
    smp(16'h0003);
    check("R4 AND both", trig_strobe, 1);
    do_stop(); wr(sa(0, 4), {14'h0, 2'd2, 16'd1});
    do_arm(); smp(16'h0002);
    check("R4 OR with B", trig_strobe, 1);
    do_stop(); wr(sa(0, 4), {14'h0, 2'd0, 16'd1});
    do_arm(); smp(16'h0002);
    check("R4 A-only ignores B", trig_strobe, 0);
    smp(16'h0001);
    check("R4 A-only with A", trig_strobe, 1);
    do_stop(); wr(sa(0, 4), {14'h0, 2'd3, 16'd1});
    do_arm(); smp(16'h0002);
    check("R4 code3 as A", trig_strobe, 0);

    // R5/R6/R7/R8 three-stage chain, width 3
    do_stop();
    wr(8'h80, 32'd2);
    wr(8'h81, 32'd3);
    stage_lvl(0, 16'h0001, 16'h0000, 2'd0, 16'd2);
    stage_lvl(1, 16'h0002, 16'h0000, 2'd0, 16'd1);
    stage_lvl(2, 16'h0004, 16'h0000, 2'd0, 16'd0);
    do_arm();
    check("R10 arm running", running, 1);
    smp(16'h0001);
    check("R5 first hit holds", cur_stage, 0);
    smp(16'h0000);
    check("R5 miss holds", cur_stage, 0);
    smp(16'h0001);
    check("R5 cumulative advance", cur_stage, 1);
    smp(16'h0001);
    check("R6 stage1 waits", cur_stage, 1);
    smp(16'h0002);
    check("R6 stage2", cur_stage, 2);
    smp(16'h0004);
    check("R7 strobe", trig_strobe, 1);
    check("R7 triggered", triggered, 1);
    begin
      int hi;
      hi = trig_out ? 1 : 0;
      for (int k = 0; k < 5; k++) begin
        smp(16'h0004);
        check("R7 no repeat strobe", trig_strobe, 0);
        if (trig_out) hi++;
      end
      check("R8 pulse width 3", hi, 3);
    end

    // R9 write while running is ignored
    do_stop();
    wr(8'h80, 32'd0);
    stage_lvl(0, 16'h0001, 16'h0000, 2'd0, 16'd1);
    do_arm();
    wr(sa(0, 1), {16'h0, 16'h0000});
    wr(sa(0, 4), {14'h0, 2'd0, 16'd5});
    wr(8'h81, 32'd9);
    smp(16'h0001);
    check("R9 config unchanged", trig_strobe, 1);
    begin
      int hi;
      hi = trig_out ? 1 : 0;
      for (int k = 0; k < 6; k++) begin
        tick();
        if (trig_out) hi++;
      end
      check("R9 width unchanged", hi, 3);
    end

    // R10 re-arm mid-sequence clears stage and counts
    do_stop();
    wr(8'h80, 32'd1);
    stage_lvl(0, 16'h0001, 16'h0000, 2'd0, 16'd2);
    stage_lvl(1, 16'h0002, 16'h0000, 2'd0, 16'd1);
    do_arm();
    smp(16'h0001); smp(16'h0001);
    check("R10 reached stage1", cur_stage, 1);
    do_arm();
    check("R10 back to 0", cur_stage, 0);
    smp(16'h0001);
    check("R10 count cleared", cur_stage, 0);
    smp(16'h0001);
    check("R10 advance after two", cur_stage, 1);

    // R11 stop returns idle, nothing fires
    do_stop();
    check("R11 idle", running, 0);
    check("R11 stage 0", cur_stage, 0);
    smp(16'h0003); smp(16'h0003); smp(16'h0003);
    check("R11 no trigger", trig_strobe | triggered, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule